// File: doc/BRIEF.md
# Conditional Partial-Order Action Sequencer

This block is the control unit that steps one instruction through its datapath actions. Each instruction class is described as a graph rather than a state list: every action (vertex) and every ordering between two actions (arc) carries a Boolean condition over the instruction-class code and two runtime mode bits. The conditions that hold for the current code and mode pick out which actions run and which orderings bind them. The controller raises a request line per action once that action's ordering constraints are met. It holds every request until all active actions have acknowledged. It then releases all of them together and pulses a done output once the handshake lines are quiet.

The two mode bits give software a runtime lever on energy without changing the class encoding. One bit chooses between a low-power and a high-performance copy of the execute unit. The two copies share the same arcs. The other bit turns on ordering arcs that force actions which could overlap to run one after another, which caps peak power. Both bits, and the class code, are captured when an instruction starts and do not change until it finishes. The datapath units themselves sit outside the block, and each talks to it through a level request/acknowledge pair.

Top module: `cpo_seq`

## Requirements
- R1: Action indices are 0 first PC increment, 1 first fetch, 2 accumulator select, 3 memory read, 4 execute (low-power copy), 5 execute (high-performance copy), 6 second PC increment, 7 memory write, 8 second fetch, 9 stack-pointer adjust. Each class raises a request on exactly its active set. Class 0 (accumulator with immediate) uses {0,1,2,3,E,6,7,8}, class 1 (fetch only) uses {0,1}, class 2 (push) uses {9,7,0,1} and class 3 (accumulator with register) uses {2,3,E,7,0,1}, where E is the execute copy selected under R4.
- R2: A request for an active action rises only after every active predecessor has acknowledged. The arcs are as follows. Class 0: 0→1, 2→3, 3→E, 1→E, 1→6, E→7, 6→8. Class 1: 0→1. Class 2: 9→7, 0→1. Class 3: 2→3, 3→E, E→7, 0→1. An action with no active predecessor is requested in the first cycle after the instruction starts.
- R3: Arcs are written from both execute copies. An arc whose source or target action is inactive for the held code and mode is ignored, so the unused copy never blocks its successors.
- R4: Mode bit 0 chooses the execute copy: 0 selects action 4 and 1 selects action 5. The two are never requested together, and the class code is the same for both.
- R5: Mode bit 1 enables the serializing arcs. These are execute→6 in class 0, 9→0 in class 2 and execute→0 in class 3. With the bit at 0, actions not otherwise ordered may be requested in the same cycle.
- R6: No request falls while any active action is still unacknowledged. When the last acknowledge has been seen, all requests fall in the same cycle.
- R7: `done_o` is high for exactly one cycle per instruction. This happens after all requests and all acknowledges are low, and never while any of them is high.
- R8: Code and mode are sampled on the `start_i` that begins an instruction and held until done. A `start_i` raised while an instruction is in progress has no effect, and it leaves no pending instruction behind.
- R9: During and after reset, with no start, all requests and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| code_i | input | 2 | Instruction-class code |
| mode_i | input | 2 | Bit 0 execute-copy select, bit 1 serialize |
| ack_i | input | 10 | Per-action acknowledge, level |
| req_o | output | 10 | Per-action request, level |
| done_o | output | 1 | One-cycle instruction-complete pulse |

## Verification
Two functions can fall in the same cycle: a request issued through the firing rule, and the concurrency that the serialize bit permits or forbids. With equal, fixed acknowledge latencies, the execute action and the second PC increment in class 0 become ready on the same edge. With the serialize bit clear, the bench expects both requests to rise in one cycle. With the bit set, the increment must rise strictly after the execute acknowledge. Each instruction in the walk records the cycle at which every request and acknowledge rises, and these records are compared pairwise. A further run drives a new start with a different code and mode while an instruction is in flight, and judges it by the set of requests raised and the number of done pulses.

// File: rtl/cpo_seq_pkg.sv
`timescale 1ns/1ps
package cpo_seq_pkg;
  localparam int unsigned N_ACT  = 10;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned MODE_W = 2;

  localparam int unsigned ACT_PC_INC0 = 0;
  localparam int unsigned ACT_FETCH0  = 1;
  localparam int unsigned ACT_ACC_SEL = 2;
  localparam int unsigned ACT_MEM_RD  = 3;
  localparam int unsigned ACT_EXE_LP  = 4;
  localparam int unsigned ACT_EXE_HP  = 5;
  localparam int unsigned ACT_PC_INC1 = 6;
  localparam int unsigned ACT_MEM_WR  = 7;
  localparam int unsigned ACT_FETCH1  = 8;
  localparam int unsigned ACT_SP_ADJ  = 9;

  localparam int unsigned M_COPY   = 0;
  localparam int unsigned M_SERIAL = 1;

  localparam logic [CODE_W-1:0] CLS_ACC_IMM = 2'b00;
  localparam logic [CODE_W-1:0] CLS_FETCH   = 2'b01;
  localparam logic [CODE_W-1:0] CLS_PUSH    = 2'b10;
  localparam logic [CODE_W-1:0] CLS_ACC_REG = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RTZ, ST_DONE} seq_state_e;

  function automatic logic [N_ACT-1:0] act_bit(input int unsigned i);
    logic [N_ACT-1:0] b;
    b    = '0;
    b[i] = 1'b1;
    return b;
  endfunction

  // vertex conditions: active action set for a code/mode pair
  function automatic logic [N_ACT-1:0] vtx_mask(input logic [CODE_W-1:0] code,
                                                input logic [MODE_W-1:0] mode);
    logic [N_ACT-1:0] exe;
    logic [N_ACT-1:0] m;
    exe = mode[M_COPY] ? act_bit(ACT_EXE_HP) : act_bit(ACT_EXE_LP);
    case (code)
      CLS_ACC_IMM: m = act_bit(ACT_PC_INC0) | act_bit(ACT_FETCH0) | act_bit(ACT_ACC_SEL)
                     | act_bit(ACT_MEM_RD) | exe | act_bit(ACT_PC_INC1)
                     | act_bit(ACT_MEM_WR) | act_bit(ACT_FETCH1);
      CLS_FETCH:   m = act_bit(ACT_PC_INC0) | act_bit(ACT_FETCH0);
      CLS_PUSH:    m = act_bit(ACT_SP_ADJ) | act_bit(ACT_MEM_WR)
                     | act_bit(ACT_PC_INC0) | act_bit(ACT_FETCH0);
      CLS_ACC_REG: m = act_bit(ACT_ACC_SEL) | act_bit(ACT_MEM_RD) | exe
                     | act_bit(ACT_MEM_WR) | act_bit(ACT_PC_INC0) | act_bit(ACT_FETCH0);
      default:     m = '0;
    endcase
    return m;
  endfunction

  // arc conditions into action v; both execute copies listed, masking drops the idle one
  function automatic logic [N_ACT-1:0] pred_mask(input int unsigned v,
                                                 input logic [CODE_W-1:0] code,
                                                 input logic [MODE_W-1:0] mode);
    logic [N_ACT-1:0] exe_any;
    logic [N_ACT-1:0] p;
    exe_any = act_bit(ACT_EXE_LP) | act_bit(ACT_EXE_HP);
    p = '0;
    case (code)
      CLS_ACC_IMM:
        case (v)
          ACT_FETCH0:             p = act_bit(ACT_PC_INC0);
          ACT_MEM_RD:             p = act_bit(ACT_ACC_SEL);
          ACT_EXE_LP, ACT_EXE_HP: p = act_bit(ACT_MEM_RD) | act_bit(ACT_FETCH0);
          ACT_PC_INC1:            p = act_bit(ACT_FETCH0) | (mode[M_SERIAL] ? exe_any : '0);
          ACT_MEM_WR:             p = exe_any;
          ACT_FETCH1:             p = act_bit(ACT_PC_INC1);
          default:                p = '0;
        endcase
      CLS_FETCH:
        if (v == ACT_FETCH0) p = act_bit(ACT_PC_INC0);
      CLS_PUSH:
        case (v)
          ACT_MEM_WR:  p = act_bit(ACT_SP_ADJ);
          ACT_FETCH0:  p = act_bit(ACT_PC_INC0);
          ACT_PC_INC0: p = mode[M_SERIAL] ? act_bit(ACT_SP_ADJ) : '0;
          default:     p = '0;
        endcase
      CLS_ACC_REG:
        case (v)
          ACT_MEM_RD:             p = act_bit(ACT_ACC_SEL);
          ACT_EXE_LP, ACT_EXE_HP: p = act_bit(ACT_MEM_RD);
          ACT_MEM_WR:             p = exe_any;
          ACT_FETCH0:             p = act_bit(ACT_PC_INC0);
          ACT_PC_INC0:            p = mode[M_SERIAL] ? exe_any : '0;
          default:                p = '0;
        endcase
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cpo_cond_eval.sv
`timescale 1ns/1ps
module cpo_cond_eval
  import cpo_seq_pkg::*;
#(
  parameter int unsigned N = N_ACT
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [N-1:0]      vact_o,
  output logic [N-1:0]      pred_o [N]
);
  assign vact_o = vtx_mask(code_i, mode_i);

  // an arc counts only if both end actions are active
  for (genvar v = 0; v < N; v++) begin : g_pred
    assign pred_o[v] = pred_mask(v, code_i, mode_i) & vact_o & {N{vact_o[v]}};
  end
endmodule

// File: rtl/cpo_fire.sv
`timescale 1ns/1ps
module cpo_fire #(
  parameter int unsigned N = 10
) (
  input  logic         en_i,
  input  logic [N-1:0] vact_i,
  input  logic [N-1:0] pred_i [N],
  input  logic [N-1:0] seen_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] fire_o
);
  for (genvar v = 0; v < N; v++) begin : g_fire
    assign fire_o[v] = en_i & vact_i[v] & ~req_i[v] & ~|(pred_i[v] & ~seen_i);
  end
endmodule

// File: rtl/cpo_ack_track.sv
`timescale 1ns/1ps
module cpo_ack_track #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] seen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_o <= '0;
    else if (clr_i) seen_o <= '0;
    else            seen_o <= seen_o | (ack_i & req_i);
  end
endmodule

// File: rtl/cpo_seq.sv
`timescale 1ns/1ps
module cpo_seq
  import cpo_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [N_ACT-1:0]  ack_i,
  output logic [N_ACT-1:0]  req_o,
  output logic              done_o
);
  seq_state_e         state_q;
  logic [CODE_W-1:0]  code_q;
  logic [MODE_W-1:0]  mode_q;
  logic [N_ACT-1:0]   req_q;
  logic [N_ACT-1:0]   vact;
  logic [N_ACT-1:0]   ack_seen;
  logic [N_ACT-1:0]   fire;
  logic [N_ACT-1:0]   pred [N_ACT];
  logic               all_acked;
  logic               run_en;
  logic               idle;

  assign run_en = (state_q == ST_RUN);
  assign idle   = (state_q == ST_IDLE);

  cpo_cond_eval #(.N(N_ACT)) u_cond (
    .code_i (code_q),
    .mode_i (mode_q),
    .vact_o (vact),
    .pred_o (pred)
  );

  cpo_fire #(.N(N_ACT)) u_fire (
    .en_i   (run_en),
    .vact_i (vact),
    .pred_i (pred),
    .seen_i (ack_seen),
    .req_i  (req_q),
    .fire_o (fire)
  );

  cpo_ack_track #(.N(N_ACT)) u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idle),
    .req_i  (req_q),
    .ack_i  (ack_i),
    .seen_o (ack_seen)
  );

  assign all_acked = ((ack_seen & vact) == vact);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      mode_q  <= '0;
      req_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          code_q  <= code_i;
          mode_q  <= mode_i;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (all_acked) begin
            req_q   <= '0;  // release every handshake at once
            state_q <= ST_RTZ;
          end else begin
            req_q <= req_q | fire;
          end
        end
        ST_RTZ:  if (ack_i == '0) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/cpo_seq_chk.sv
`timescale 1ns/1ps
module cpo_seq_chk
  import cpo_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ACT-1:0]  req_i,
  input logic [N_ACT-1:0]  ack_i,
  input logic [N_ACT-1:0]  seen_i,
  input logic              done_i,
  input seq_state_e        state_i,
  input logic [CODE_W-1:0] code_i,
  input logic [MODE_W-1:0] mode_i
);
  a_r2_fetch_after_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i[ACT_FETCH0]) |-> seen_i[ACT_PC_INC0]);

  a_r4_one_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i[ACT_EXE_LP] && req_i[ACT_EXE_HP]));

  a_r4_copy_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[ACT_EXE_HP] |-> mode_i[M_COPY]) and (req_i[ACT_EXE_LP] |-> !mode_i[M_COPY]));

  a_r5_serial_inc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i[ACT_PC_INC1]) && mode_i[M_SERIAL] |-> (seen_i[ACT_EXE_LP] || seen_i[ACT_EXE_HP]));

  a_r5_serial_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i[ACT_PC_INC0]) && mode_i[M_SERIAL] && code_i == CLS_PUSH |-> seen_i[ACT_SP_ADJ]);

  a_r5_serial_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i[ACT_PC_INC0]) && mode_i[M_SERIAL] && code_i == CLS_ACC_REG
      |-> (seen_i[ACT_EXE_LP] || seen_i[ACT_EXE_HP]));

  a_r6_drop_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(req_i) & ~req_i)) |-> (req_i == '0));

  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (req_i == '0) && (ack_i == '0));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) && ($past(state_i) != ST_IDLE) |-> $stable(code_i) && $stable(mode_i));
endmodule

bind cpo_seq cpo_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_o),
  .ack_i   (ack_i),
  .seen_i  (ack_seen),
  .done_i  (done_o),
  .state_i (state_q),
  .code_i  (code_q),
  .mode_i  (mode_q)
);

// File: tb/cpo_seq_bench.sv
`timescale 1ns/1ps
module cpo_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [1:0] code_i;
  logic [1:0] mode_i;
  logic [9:0] ack_i = '0;
  logic [9:0] req_o;
  logic       done_o;

  always #2 clk_i = ~clk_i;

  cpo_seq u_cpo_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .code_i (code_i),
    .mode_i (mode_i), .ack_i (ack_i), .req_o (req_o), .done_o (done_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected active sets (R1)
  function automatic logic [9:0] tb_mask(input logic [1:0] c, input logic [1:0] m);
    case (c)
      2'd0:    return m[0] ? 10'h1EF : 10'h1DF;
      2'd1:    return 10'h003;
      2'd2:    return 10'h283;
      default: return m[0] ? 10'h0AF : 10'h09F;
    endcase
  endfunction

  // expected predecessors (R2, R5)
  function automatic logic [9:0] tb_pred(input logic [1:0] c, input logic [1:0] m, input int v);
    logic [9:0] p;
    p = '0;
    case (c)
      2'd0: case (v)
        1: p = 10'h001;
        3: p = 10'h004;
        4, 5: p = 10'h00A;
        6: p = 10'h002 | (m[1] ? 10'h030 : 10'h000);
        7: p = 10'h030;
        8: p = 10'h040;
        default: p = '0;
      endcase
      2'd1: if (v == 1) p = 10'h001;
      2'd2: case (v)
        7: p = 10'h200;
        1: p = 10'h001;
        0: p = m[1] ? 10'h200 : 10'h000;
        default: p = '0;
      endcase
      default: case (v)
        3: p = 10'h004;
        4, 5: p = 10'h008;
        7: p = 10'h030;
        1: p = 10'h001;
        0: p = m[1] ? 10'h030 : 10'h000;
        default: p = '0;
      endcase
    endcase
    return p;
  endfunction

  // row: code[23:22] mode[21:20] mask[19:10] kind[9:8] u[7:4] v[3:0]; kind 1 = v after ack of u, 2 = same cycle
  localparam logic [23:0] ROWS [10] = '{
    {2'd0, 2'd0, 10'h1DF, 2'd2, 4'd4, 4'd6},
    {2'd0, 2'd2, 10'h1DF, 2'd1, 4'd4, 4'd6},
    {2'd0, 2'd1, 10'h1EF, 2'd2, 4'd5, 4'd6},
    {2'd0, 2'd3, 10'h1EF, 2'd1, 4'd5, 4'd6},
    {2'd1, 2'd0, 10'h003, 2'd1, 4'd0, 4'd1},
    {2'd2, 2'd0, 10'h283, 2'd2, 4'd9, 4'd0},
    {2'd2, 2'd2, 10'h283, 2'd1, 4'd9, 4'd0},
    {2'd3, 2'd0, 10'h09F, 2'd2, 4'd2, 4'd0},
    {2'd3, 2'd3, 10'h0AF, 2'd1, 4'd5, 4'd0},
    {2'd3, 2'd1, 10'h0AF, 2'd1, 4'd5, 4'd7}
  };

  logic [1:0] cur_code = '0;
  logic [1:0] cur_mode = '0;
  logic [9:0] cur_mask = '0;
  int         cur_lat  = 0;
  logic [9:0] seen_mask = '0;
  logic [9:0] acked_tb = '0;
  int         done_cnt = 0;
  int         rise_req [10];
  int         rise_ack [10];

  // datapath model and monitor, all at the falling edge
  initial begin
    logic [9:0] req_prev;
    logic [9:0] ack_q;
    logic       done_prev;
    int         cnt [10];
    int         cyc;
    req_prev = '0; ack_q = '0; done_prev = 1'b0; cyc = 0;
    for (int v = 0; v < 10; v++) cnt[v] = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (!rst_ni) begin
        ack_q = '0; req_prev = '0; done_prev = 1'b0; ack_i = '0;
        continue;
      end
      for (int v = 0; v < 10; v++)
        if (ack_q[v] && !acked_tb[v]) begin acked_tb[v] = 1'b1; rise_ack[v] = cyc; end
      for (int v = 0; v < 10; v++) begin
        if (req_o[v] && !req_prev[v]) begin
          logic [9:0] pm;
          rise_req[v]  = cyc;
          seen_mask[v] = 1'b1;
          pm = tb_pred(cur_code, cur_mode, v) & cur_mask;
          chk((pm & ~acked_tb) == '0, "R2 request before predecessor ack", pm & ~acked_tb, 0);
          cnt[v] = (cur_lat < 0) ? $urandom_range(4, 0) : cur_lat;
        end
        if (!req_o[v] && req_prev[v])
          cnt[v] = (cur_lat < 0) ? $urandom_range(4, 0) : cur_lat;
      end
      if (|(req_prev & ~req_o))
        chk(req_o == '0 && (cur_mask & ~acked_tb) == '0, "R6 early or partial release",
            {req_o, 6'd0, cur_mask & ~acked_tb}, 0);
      if (done_o) begin
        done_cnt++;
        chk(req_o == '0 && ack_q == '0 && !done_prev, "R7 done with lines active",
            {req_o, ack_q, 3'd0, done_prev}, 0);
      end
      for (int v = 0; v < 10; v++) begin
        if (req_o[v] && !ack_q[v]) begin
          if (cnt[v] == 0) ack_q[v] = 1'b1; else cnt[v]--;
        end else if (!req_o[v] && ack_q[v]) begin
          if (cnt[v] == 0) ack_q[v] = 1'b0; else cnt[v]--;
        end
      end
      ack_i     = ack_q;
      req_prev  = req_o;
      done_prev = done_o;
    end
  end

  task automatic run_instr(input logic [1:0] c, input logic [1:0] m, input logic [9:0] exp_mask,
                           input int lat, input bit inject, input logic [1:0] kind,
                           input int u, input int v);
    @(posedge clk_i);
    cur_code = c; cur_mode = m; cur_mask = exp_mask; cur_lat = lat;
    seen_mask = '0; acked_tb = '0; done_cnt = 0;
    for (int i = 0; i < 10; i++) begin rise_req[i] = 0; rise_ack[i] = 0; end
    @(negedge clk_i);
    start_i = 1'b1; code_i = c; mode_i = m;
    @(negedge clk_i);
    start_i = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; code_i = 2'd2; mode_i = 2'd3;
      repeat (3) @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int t = 0; t < 400 && done_cnt == 0; t++) @(posedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(seen_mask == exp_mask, "R1 requested set", seen_mask, exp_mask);
    chk(done_cnt == 1, "R7 done pulses per instruction", done_cnt, 1);
    if (kind == 2'd1)
      chk(rise_req[v] > rise_ack[u], "R5 serialized order (R3 for idle copy)", rise_req[v], rise_ack[u] + 1);
    else if (kind == 2'd2)
      chk(rise_req[v] == rise_req[u], "R5 concurrent start", rise_req[v], rise_req[u]);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; code_i = '0; mode_i = '0;
    repeat (3) @(negedge clk_i);
    chk(req_o == '0 && !done_o, "R9 outputs in reset", {req_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(req_o == '0 && !done_o, "R9 idle after reset", {req_o, done_o}, 0);

    for (int i = 0; i < 10; i++)
      run_instr(ROWS[i][23:22], ROWS[i][21:20], ROWS[i][19:10], 2, 1'b0,
                ROWS[i][9:8], int'(ROWS[i][7:4]), int'(ROWS[i][3:0]));

    // random latencies over every code/mode pair: R1, R2, R4, R6, R7
    for (int k = 0; k < 16; k++)
      for (int r = 0; r < 3; r++)
        run_instr(k[3:2], k[1:0], tb_mask(k[3:2], k[1:0]), -1, 1'b0, 2'd0, 0, 0);

    // R8: start with other code/mode while running is ignored
    run_instr(2'd0, 2'd0, 10'h1DF, 3, 1'b1, 2'd2, 4, 6);
    repeat (6) @(negedge clk_i);
    chk(req_o == '0 && !done_o, "R8 no instruction from ignored start", {req_o, done_o}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule